// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind an Ethernet receiver and decides whether a frame is kept or dropped based on its destination address. The receiver hands over the six destination bytes one at a time, marking the first of them with a start strobe. The filter compares the bytes against a programmed station address as they arrive. In the same pass it builds a CRC-32 of the address. Once the sixth byte has been taken, it registers a single accept or reject verdict.

Four rules can accept a frame. A promiscuous control accepts everything. The all-ones broadcast address is always accepted. Multicast frames are accepted either by a pass-all control or by a lookup in a 64-bit hash table held as two 32-bit words. Unicast frames must match the station address exactly. The verdict stays on the outputs until the next frame begins, so downstream logic can sample it at leisure.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `decisionValid` and `accept` are both 0, and address bytes arriving without a preceding `sop` are ignored.
- R2: An address byte is taken when `byteValid` is 1. A byte taken with `sop` = 1 is address byte 0. `decisionValid` goes to 1 in the cycle after the sixth byte is taken, and goes to 0 in the cycle after the next `sop` byte. Gaps with `byteValid` = 0 may appear between bytes. Bytes after the sixth and before the next `sop` have no effect.
- R3: A unicast frame (bit 0 of byte 0 equal to 0) is accepted only if all six bytes equal the station address. `stationLo[7:0]` is byte 0, `stationLo[15:8]` is byte 1, `stationLo[23:16]` is byte 2 and `stationLo[31:24]` is byte 3. `stationHi[7:0]` is byte 4 and `stationHi[15:8]` is byte 5.
- R4: The address FF:FF:FF:FF:FF:FF is accepted whatever the mode inputs are.
- R5: With `promiscEn` = 1, every frame is accepted.
- R6: With `allMultiEn` = 1, every multicast frame (bit 0 of byte 0 equal to 1) is accepted without a hash lookup.
- R7: With `hashEn` = 1, a multicast frame is accepted when the hash table bit selected by a 6-bit index is set. The index is found as follows:
  - The CRC register is preset to all ones.
  - The address bytes are fed in order, bit 0 of each byte first.
  - On each input bit, the register shifts left. When the input bit XOR the old register bit 31 is 1, the register is XORed with 0x04C11DB7.
  - No final inversion is applied.
  - The index is register bits 31..26.
  - Index bit 5 equal to 1 selects `hashHi`, and 0 selects `hashLo`. Index bits 4..0 select the bit within that word.
- R8: A multicast frame that is not broadcast is rejected when `promiscEn`, `allMultiEn` and `hashEn` are all 0. It is also rejected when only `hashEn` is set and the selected hash bit is 0.
- R9: While `decisionValid` stays 1, `accept` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | An address byte is present on `byteData` |
| sop | input | 1 | Marks the present byte as address byte 0 |
| byteData | input | 8 | Destination address byte |
| stationLo | input | 32 | Station address bytes 0 to 3 |
| stationHi | input | 16 | Station address bytes 4 and 5 |
| hashLo | input | 32 | Hash table bits for index 0 to 31 |
| hashHi | input | 32 | Hash table bits for index 32 to 63 |
| promiscEn | input | 1 | Accept every frame |
| allMultiEn | input | 1 | Accept every multicast frame |
| hashEn | input | 1 | Enable the hash lookup for multicast frames |
| decisionValid | output | 1 | Verdict for the current frame is available |
| accept | output | 1 | Verdict: 1 keeps the frame, 0 drops it |

## Verification
The assertions assume three things about the inputs. First, the station address, hash words and mode inputs are held steady from a frame's `sop` byte until its sixth byte. This matters because the station comparison is made byte by byte as the frame arrives. Second, `sop` is only raised together with `byteValid`. Third, the inputs are known once reset is released. The stimulus respects all three: it changes the configuration only in idle cycles between frames, and it always drives `sop` and `byteValid` as a pair. Within those limits it varies the gap lengths, sends surplus bytes after the sixth, and starts new frames back to back.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
  parameter int ADDR_BYTES = 6;
  parameter int BYTE_W     = 8;
  parameter int CRC_W      = 32;
  parameter int HASH_BITS  = 6;
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam int IDX_W = $clog2(ADDR_BYTES);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  typedef struct packed {
    logic             take;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] idx;
  } byteStrobe_t;

  function automatic logic [CRC_W-1:0] crcStepByte(input logic [CRC_W-1:0] cur,
                                                   input logic [BYTE_W-1:0] data);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/rx_dest_filter_ctrl.sv
module rx_dest_filter_ctrl
  import rx_dest_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        sop,
  output byteStrobe_t strobe
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobe.take  = byteValid && (sop || (cnt < CNT_W'(ADDR_BYTES)));
    strobe.idx   = sop ? '0 : cnt[IDX_W-1:0];
    strobe.first = strobe.take && (strobe.idx == '0);
    strobe.last  = strobe.take && (strobe.idx == IDX_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= CNT_W'(ADDR_BYTES);
    else if (strobe.take) cnt <= CNT_W'(strobe.idx) + CNT_W'(1);
  end

  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (strobe.idx < IDX_W'(ADDR_BYTES)));
  a_r2_follow_on: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.last) ##1 (byteValid && !sop) |-> strobe.take);
endmodule

// File: rtl/rx_dest_filter_dp.sv
module rx_dest_filter_dp
  import rx_dest_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  byteStrobe_t       strobe,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [31:0]       stationLo,
  input  logic [15:0]       stationHi,
  input  logic [31:0]       hashLo,
  input  logic [31:0]       hashHi,
  input  logic              promiscEn,
  input  logic              allMultiEn,
  input  logic              hashEn,
  output logic              decisionValid,
  output logic              accept
);
  localparam int ST_W = ADDR_BYTES * BYTE_W;

  logic [ST_W-1:0]   stationAddr;
  logic [BYTE_W-1:0] stBytes [ADDR_BYTES];
  logic [CRC_W-1:0]  crcReg, crcBase, crcNext;
  logic              matchReg, bcastReg, mcastReg;
  logic              matchNext, bcastNext, mcastNext;
  logic [HASH_BITS-1:0] hashIdx;
  logic [31:0]       hashWord;
  logic              hashHit, verdict;

  assign stationAddr = {stationHi, stationLo};

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gStByte
    assign stBytes[g] = stationAddr[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    crcBase   = strobe.first ? '1 : crcReg;
    crcNext   = crcStepByte(crcBase, byteData);
    matchNext = (strobe.first || matchReg) && (byteData == stBytes[strobe.idx]);
    bcastNext = (strobe.first || bcastReg) && (byteData == '1);
    mcastNext = strobe.first ? byteData[0] : mcastReg;
    hashIdx   = crcNext[CRC_W-1 -: HASH_BITS];
    hashWord  = hashIdx[HASH_BITS-1] ? hashHi : hashLo;
    hashHit   = hashWord[hashIdx[HASH_BITS-2:0]];
    verdict   = promiscEn || bcastNext
             || (mcastNext && (allMultiEn || (hashEn && hashHit)))
             || (!mcastNext && matchNext);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg        <= '1;
      matchReg      <= 1'b0;
      bcastReg      <= 1'b0;
      mcastReg      <= 1'b0;
      decisionValid <= 1'b0;
      accept        <= 1'b0;
    end else if (strobe.take) begin
      crcReg   <= crcNext;
      matchReg <= matchNext;
      bcastReg <= bcastNext;
      mcastReg <= mcastNext;
      if (strobe.first) decisionValid <= 1'b0;
      if (strobe.last) begin
        decisionValid <= 1'b1;
        accept        <= verdict;
      end
    end
  end

  a_r9_hold_verdict: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && $past(decisionValid)) |-> $stable(accept));
  a_r2_valid_after_last: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> decisionValid);
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.first && !strobe.last) |=> !decisionValid);
  a_r5_promisc_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.last && promiscEn) |=> accept);
  a_r6_allmulti_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.last && allMultiEn && mcastReg) |=> accept);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        sop,
  input  logic [7:0]  byteData,
  input  logic [31:0] stationLo,
  input  logic [15:0] stationHi,
  input  logic [31:0] hashLo,
  input  logic [31:0] hashHi,
  input  logic        promiscEn,
  input  logic        allMultiEn,
  input  logic        hashEn,
  output logic        decisionValid,
  output logic        accept
);
  byteStrobe_t strobe;

  rx_dest_filter_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .sop       (sop),
    .strobe    (strobe)
  );

  rx_dest_filter_dp uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .byteData      (byteData),
    .stationLo     (stationLo),
    .stationHi     (stationHi),
    .hashLo        (hashLo),
    .hashHi        (hashHi),
    .promiscEn     (promiscEn),
    .allMultiEn    (allMultiEn),
    .hashEn        (hashEn),
    .decisionValid (decisionValid),
    .accept        (accept)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!decisionValid && !accept));
endmodule

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, sop = 1'b0;
  logic [7:0] byteData = '0;
  logic [31:0] stationLo = '0;
  logic [15:0] stationHi = '0;
  logic [31:0] hashLo = '0, hashHi = '0;
  logic promiscEn = 1'b0, allMultiEn = 1'b0, hashEn = 1'b0;
  logic decisionValid, accept;

  always #4 clk = ~clk;

  rx_dest_filter uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sop(sop), .byteData(byteData),
    .stationLo(stationLo), .stationHi(stationHi), .hashLo(hashLo), .hashHi(hashHi),
    .promiscEn(promiscEn), .allMultiEn(allMultiEn), .hashEn(hashEn),
    .decisionValid(decisionValid), .accept(accept)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string curReq = "R1";

  logic [7:0] mBuf [6];
  int   mCnt = 6;
  logic mValid = 0, mAccept = 0;

  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      logic b = a[n] ^ r[31];
      r = r << 1;
      if (b) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction

  function automatic logic [47:0] bufAddr();
    logic [47:0] a;
    for (int i = 0; i < 6; i++) a[8*i +: 8] = mBuf[i];
    return a;
  endfunction

  function automatic logic decide(input logic [47:0] a);
    logic [31:0] c;
    int idx;
    logic hit;
    c   = refCrc(a);
    idx = int'(c[31:26]);
    hit = (idx >= 32) ? hashHi[idx-32] : hashLo[idx];
    if (promiscEn) return 1'b1;
    if (a == {48{1'b1}}) return 1'b1;
    if (a[0]) return allMultiEn || (hashEn && hit);
    return a == {stationHi, stationLo};
  endfunction

  task automatic modelUpdate(input logic v, input logic s, input logic [7:0] d);
    if (!v) return;
    if (s) begin mCnt = 0; mValid = 0; end
    if (mCnt < 6) begin
      mBuf[mCnt] = d;
      mCnt++;
      if (mCnt == 6) begin mValid = 1; mAccept = decide(bufAddr()); end
    end
  endtask

  task automatic compare();
    checks++;
    if (decisionValid !== mValid || accept !== mAccept) begin
      fails++;
      $display("FAIL %s: valid/accept act=%b/%b exp=%b/%b at cycle %0d",
               curReq, decisionValid, accept, mValid, mAccept, cycles);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d);
    @(negedge clk);
    compare();
    byteValid = v; sop = s; byteData = d;
    modelUpdate(v, s, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic sendFrame(input logic [47:0] a, input int gap, input int extra);
    for (int i = 0; i < 6; i++) begin
      step(1'b1, i == 0, a[8*i +: 8]);
      if (gap > 0) idle(gap);
    end
    for (int i = 0; i < extra; i++) step(1'b1, 1'b0, 8'hA5 ^ 8'(i));
    idle(2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL R2: watchdog act=%0d cycles exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [31:0] c;
    int ix;
    // R1: reset state, and bytes without sop are ignored
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    stationLo = 32'h3322_1100; stationHi = 16'h5544;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'(i));
    idle(2);

    // R3: exact station match accepted, mismatches rejected
    curReq = "R3";
    sendFrame(48'h5544_3322_1100, 0, 0);
    sendFrame(48'h5644_3322_1100, 0, 0);
    sendFrame(48'h5544_3322_1102, 0, 0);
    sendFrame(48'h5544_3323_1100, 1, 0);

    // R4: broadcast with every mode off
    curReq = "R4";
    sendFrame({48{1'b1}}, 0, 0);
    sendFrame(48'hFFFF_FFFF_FFFE, 0, 0);

    // R5: promiscuous
    curReq = "R5";
    promiscEn = 1'b1;
    sendFrame(48'h1234_5678_9ABC, 0, 0);
    sendFrame(48'h0000_0000_0001, 0, 0);
    promiscEn = 1'b0;

    // R8: multicast with nothing enabled
    curReq = "R8";
    sendFrame(48'h0100_005E_0001, 0, 0);

    // R6: pass-all multicast
    curReq = "R6";
    allMultiEn = 1'b1;
    sendFrame(48'h0100_005E_0001, 0, 0);
    sendFrame(48'h0100_005E_0000, 0, 0);
    allMultiEn = 1'b0;

    // R7: hash lookup, single-bit table then inverted table
    curReq = "R7";
    hashEn = 1'b1;
    for (int k = 0; k < 12; k++) begin
      a = {8'(k * 37), 8'(k * 11), 8'h5E, 8'h00, 8'h00, 8'h01 | 8'(k << 1)};
      c = refCrc(a);
      ix = int'(c[31:26]);
      hashLo = '0; hashHi = '0;
      if (ix >= 32) hashHi[ix-32] = 1'b1; else hashLo[ix] = 1'b1;
      idle(1);
      sendFrame(a, k % 2, 0);
      hashLo = ~hashLo; hashHi = ~hashHi;
      idle(1);
      curReq = "R8";
      sendFrame(a, 0, 0);
      curReq = "R7";
    end
    hashEn = 1'b0; hashLo = '1; hashHi = '1;
    curReq = "R8";
    sendFrame(48'h0100_005E_0007, 0, 0);
    hashLo = '0; hashHi = '0;

    // R2: surplus bytes, gaps, back-to-back frames; R9 hold while idling
    curReq = "R2";
    sendFrame(48'h5544_3322_1100, 0, 4);
    sendFrame(48'h5544_3322_1100, 3, 0);
    for (int i = 0; i < 6; i++) step(1'b1, i == 0, 8'(8'h00 + 8'(i * 17)));
    for (int i = 0; i < 6; i++) step(1'b1, i == 0, 8'hFF);
    curReq = "R9";
    idle(10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule